// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles even parity for a 32-bit multiplexed address/data bus with four command/byte-enable lines. When the surrounding bus interface says the device is driving the address/data lines, the block produces the matching parity bit one clock later and enables its output driver. When the device is receiving, the block captures the address/data and command lines of each valid phase. It compares them with the parity bit that arrives on the following clock and reports any mismatch two clocks after the phase.

Errors on received data phases are reported on the parity-error line. Errors on received address phases, and on data phases of special cycles, are reported on the system-error line instead. Each reporting path is gated by its own enable input. A sticky detected-error bit records every parity mismatch whatever the enables are, and only reset clears it. All report outputs are active high. Any inversion for the bus pins belongs to the pad logic outside this block.

Top module: `pci_parity_unit`

## Requirements
- R1: When `drive_ad` is high in cycle N, `par_out` in cycle N+1 equals the XOR of all 32 `ad_in` bits and all 4 `cbe_in` bits from cycle N, which gives even parity over the 37 lines.
- R2: `par_oe` is high in cycle N+1 exactly when `drive_ad` was high in cycle N.
- R3: A received data phase in cycle N (`data_phase`=1, `drive_ad`=0, `addr_phase`=0, `special_cyc`=0) whose `par_in` in cycle N+1 mismatches gives `perr_out`=1 for the single cycle N+2, provided `perr_en`=1. Back-to-back errored phases give one pulse per phase.
- R4: `perr_oe` is high in cycle N+2 exactly for received, non-special data phases in cycle N while `perr_en`=1, whether or not the parity matched. It is never high for a phase the device drove.
- R5: A parity mismatch on a received data phase with `special_cyc`=1 pulses `serr_out` in cycle N+2 (when `serr_en`=1). `perr_out` and `perr_oe` stay low for that phase.
- R6: A parity mismatch on a received address phase (`addr_phase`=1, which takes priority over `data_phase`) pulses `serr_out` in cycle N+2 when `serr_en`=1, with no parity-error report.
- R7: With `perr_en`=0, `perr_out` and `perr_oe` stay low, even for errored data phases.
- R8: With `serr_en`=0, `serr_out` stays low, even for errored address or special-cycle phases.
- R9: `det_err` goes high in cycle N+2 after any received phase with a parity mismatch, regardless of `perr_en` and `serr_en`. It stays high until reset.
- R10: While `rst_n` is low, `par_out`, `par_oe`, `perr_out`, `perr_oe`, `serr_out` and `det_err` are all low.
- R11: A wrong `par_in` has no effect after a cycle with no valid phase, or after a phase the device drove: no error report and no change of `det_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_in | input | 32 | Address/data lines as seen on the bus |
| cbe_in | input | 4 | Command/byte-enable lines as seen on the bus |
| par_in | input | 1 | Parity line as seen on the bus |
| drive_ad | input | 1 | Device drives the address/data lines this cycle |
| addr_phase | input | 1 | Valid address phase this cycle |
| data_phase | input | 1 | Valid completed data phase this cycle |
| special_cyc | input | 1 | Current transaction is a special cycle |
| perr_en | input | 1 | Enables parity-error reporting |
| serr_en | input | 1 | Enables system-error reporting |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Output enable for the parity line |
| perr_out | output | 1 | Parity-error report (active high) |
| perr_oe | output | 1 | Output enable for the parity-error line |
| serr_out | output | 1 | System-error report (active high) |
| det_err | output | 1 | Sticky parity-error detected status |

## Verification
The bench sends mismatching parity after driven phases and after idle cycles. A design that checked every cycle, or ignored direction, would then raise false errors or set the sticky bit. It runs errored special-cycle and address phases, which a design with the wrong routing would report on the parity-error line. It runs back-to-back errored data phases, where a design with a stretched or merged pulse would show the wrong count of cycles. It also checks errors with both enables off, where the sticky bit must still set but no report may appear. A design that gated detection by the enables would leave the status clear.

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_in,
  input  logic [CBE_W-1:0] cbe_in,
  input  logic             par_in,
  input  logic             drive_ad,
  input  logic             addr_phase,
  input  logic             data_phase,
  input  logic             special_cyc,
  input  logic             perr_en,
  input  logic             serr_en,
  output logic             par_out,
  output logic             par_oe,
  output logic             perr_out,
  output logic             perr_oe,
  output logic             serr_out,
  output logic             det_err
);

  logic bus_par;
  logic s1_chk, s1_addr, s1_spec, s1_par;
  logic mismatch, to_serr;

  assign bus_par  = ^{ad_in, cbe_in};
  assign mismatch = s1_chk && (s1_par != par_in);
  assign to_serr  = s1_addr || s1_spec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_out  <= 1'b0;
      par_oe   <= 1'b0;
      s1_chk   <= 1'b0;
      s1_addr  <= 1'b0;
      s1_spec  <= 1'b0;
      s1_par   <= 1'b0;
      perr_out <= 1'b0;
      perr_oe  <= 1'b0;
      serr_out <= 1'b0;
      det_err  <= 1'b0;
    end else begin
      par_out  <= bus_par;
      par_oe   <= drive_ad;
      s1_chk   <= !drive_ad && (addr_phase || data_phase);
      s1_addr  <= addr_phase;
      s1_spec  <= special_cyc;
      s1_par   <= bus_par;
      perr_oe  <= s1_chk && !to_serr && perr_en;
      perr_out <= mismatch && !to_serr && perr_en;
      serr_out <= mismatch && to_serr && serr_en;
      if (mismatch) det_err <= 1'b1;
    end
  end

  p_par_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> $past(drive_ad));
  p_par_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> (^{par_out, $past(ad_in), $past(cbe_in)}) == 1'b0);
  p_perr_oe_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    perr_oe |-> ($past(data_phase, 2) && !$past(drive_ad, 2)));
  p_perr_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    perr_out |-> ($past(perr_en) && perr_oe));
  p_serr_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    serr_out |-> $past(serr_en));
  p_no_perr_special_r5: assert property (@(posedge clk) disable iff (!rst_n)
    perr_out |-> !$past(special_cyc, 2));
  p_one_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(perr_out && serr_out));
  p_det_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    det_err |=> det_err);

endmodule

// File: tb/pci_parity_unit_bench.sv
module pci_parity_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_in = '0;
  logic        par_in = 1'b0;
  logic        drive_ad = 1'b0, addr_phase = 1'b0, data_phase = 1'b0, special_cyc = 1'b0;
  logic        perr_en = 1'b0, serr_en = 1'b0;
  logic        par_out, par_oe, perr_out, perr_oe, serr_out, det_err;

  pci_parity_unit u_pci_parity_unit (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_in(cbe_in), .par_in(par_in),
    .drive_ad(drive_ad), .addr_phase(addr_phase), .data_phase(data_phase),
    .special_cyc(special_cyc), .perr_en(perr_en), .serr_en(serr_en),
    .par_out(par_out), .par_oe(par_oe), .perr_out(perr_out), .perr_oe(perr_oe),
    .serr_out(serr_out), .det_err(det_err));

  always #2 clk = ~clk;

  typedef struct {
    int    cyc;
    bit    is_par;
    bit    e_oe, e_par, e_perr_oe, e_perr, e_serr, e_det;
    string req;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    checks = 0, failures = 0;
  bit    mon_on = 1'b0, done = 1'b0;
  bit    pend_par = 1'b0, det_model = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mon_on) begin
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        item_t it;
        it = q.pop_front();
        if (it.cyc == cyc) begin
          checks++;
          if (it.is_par) begin
            if (par_oe !== it.e_oe || (it.e_oe && par_out !== it.e_par)) begin
              failures++;
              $display("FAIL %s cyc=%0d par_oe/par_out actual=%b%b expected=%b%b",
                       it.req, cyc, par_oe, par_out, it.e_oe, it.e_par);
            end
          end else if (perr_oe !== it.e_perr_oe || perr_out !== it.e_perr ||
                       serr_out !== it.e_serr || det_err !== it.e_det) begin
            failures++;
            $display("FAIL %s cyc=%0d perr_oe/perr/serr/det actual=%b%b%b%b expected=%b%b%b%b",
                     it.req, cyc, perr_oe, perr_out, serr_out, det_err,
                     it.e_perr_oe, it.e_perr, it.e_serr, it.e_det);
          end
        end
      end
    end
  end

  task automatic step(input logic [31:0] ad, input logic [3:0] cbe, input bit drv,
                      input bit adr, input bit dat, input bit spc, input bit bad,
                      input string req);
    item_t p, e;
    bit rx, err;
    @(negedge clk);
    par_in = pend_par;
    ad_in = ad; cbe_in = cbe; drive_ad = drv;
    addr_phase = adr; data_phase = dat; special_cyc = spc;
    pend_par = (^{ad, cbe}) ^ bad;
    rx  = !drv && (adr || dat);
    err = rx && bad;
    det_model = det_model | err;
    p = '{cyc: cyc + 1, is_par: 1'b1, e_oe: drv, e_par: ^{ad, cbe},
          e_perr_oe: 1'b0, e_perr: 1'b0, e_serr: 1'b0, e_det: 1'b0, req: "R1,R2"};
    e = '{cyc: cyc + 2, is_par: 1'b0, e_oe: 1'b0, e_par: 1'b0,
          e_perr_oe: rx && !adr && !spc && perr_en,
          e_perr: err && !adr && !spc && perr_en,
          e_serr: err && (adr || spc) && serr_en,
          e_det: det_model, req: req};
    q.push_back(p);
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(32'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic check_low(input string req);
    checks++;
    if ({par_out, par_oe, perr_out, perr_oe, serr_out, det_err} !== 6'b0) begin
      failures++;
      $display("FAIL %s reset outputs actual=%b expected=000000", req,
               {par_out, par_oe, perr_out, perr_oe, serr_out, det_err});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_low("R10");
    rst_n = 1'b1;
    mon_on = 1'b1;
    // R1 R2 R11: driven phases with wrong parity returned, then idle with wrong parity
    step(32'h0000_0000, 4'h0, 1, 0, 1, 0, 1, "R11");
    step(32'hFFFF_FFFF, 4'h1, 1, 0, 1, 0, 1, "R11");
    step(32'h1234_5678, 4'hA, 1, 1, 0, 0, 1, "R11");
    step(32'hA5A5_0F0F, 4'h7, 1, 0, 1, 0, 1, "R11");
    step(32'h8000_0001, 4'hF, 0, 0, 0, 0, 1, "R11");
    step(32'h0000_0003, 4'h8, 0, 0, 0, 0, 1, "R11");
    idle(2, "R11");
    // R7 R8 R9: enables off, errors still set the sticky bit
    step(32'hDEAD_BEEF, 4'h3, 0, 0, 1, 0, 1, "R7");
    step(32'h0F0F_0F0F, 4'hC, 0, 1, 0, 0, 1, "R8");
    step(32'h0000_1111, 4'h2, 0, 0, 1, 1, 1, "R8");
    idle(2, "R9");
    perr_en = 1'b1; serr_en = 1'b1;
    step(32'h1357_9BDF, 4'h5, 0, 0, 1, 0, 0, "R4");
    step(32'h2468_ACE0, 4'h6, 0, 0, 1, 0, 0, "R4");
    step(32'hCAFE_F00D, 4'h9, 0, 0, 1, 0, 1, "R3");
    step(32'h0BAD_CAFE, 4'hE, 0, 0, 1, 0, 1, "R3");
    step(32'h7777_7777, 4'h1, 0, 0, 1, 0, 0, "R3");
    step(32'h5555_AAAA, 4'h4, 0, 0, 1, 1, 1, "R5");
    step(32'h5555_AAAB, 4'h4, 0, 0, 1, 1, 0, "R5");
    step(32'h1000_0000, 4'hB, 0, 1, 0, 0, 1, "R6");
    step(32'h1000_0001, 4'hB, 0, 1, 1, 0, 1, "R6");
    step(32'h1000_0002, 4'hB, 0, 1, 0, 0, 0, "R6");
    idle(2, "R6");
    step(32'h3333_0000, 4'h0, 1, 0, 1, 0, 1, "R4");
    step(32'h3333_0001, 4'h1, 0, 0, 1, 0, 1, "R4");
    step(32'h3333_0002, 4'h2, 1, 0, 1, 0, 1, "R4");
    step(32'h3333_0003, 4'h3, 0, 0, 1, 0, 0, "R4");
    idle(2, "R4");
    repeat (3) @(negedge clk);
    // R9 R10: reset clears the sticky status
    mon_on = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_low("R9");
    rst_n = 1'b1;
    q.delete();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule